// File: doc/BRIEF.md
# Two-Tier Row Protection Controller

The controller accepts single-word read and write requests and turns each into a short series of accesses on a shared array port that reaches `N_DATA` data chips and one parity chip. Every word a data chip holds carries an 8-bit checksum alongside it. The checksum only detects errors. The parity chip holds, for each row, the XOR of that row across all data chips, and it is used to rebuild the word of one failed chip.

A read that passes its checksum costs one array access. A read that fails triggers a rebuild. The controller reads the same row from every other data chip and from the parity chip, in ascending chip order. It XORs those words together and checks the result against the stored checksum. It then returns the rebuilt word with a corrected flag, or reports an uncorrectable error. A write reads the old word and the old parity, then writes the new word with its fresh checksum and the updated parity. Only one request is in flight at a time.

States and transitions: `S_IDLE` goes to `S_RD_DATA` on an accepted read and to `S_WR_RD_DATA` on an accepted write. `S_RD_DATA` goes to `S_RD_CHECK`. `S_RD_CHECK` goes back to `S_IDLE` when the checksum matches and to `S_RB_ISSUE` when it does not. `S_RB_ISSUE` goes to `S_RB_ACC`. `S_RB_ACC` goes back to `S_RB_ISSUE` until the parity chip has been folded in, then goes to `S_RB_CHECK`. `S_RB_CHECK` goes to `S_IDLE`. The write path runs `S_WR_RD_DATA`, then `S_WR_RD_PAR`, then `S_WR_WR_DATA`, then `S_WR_WR_PAR`, then returns to `S_IDLE`.

Top module: `rowguard_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: `req_ready` is high only when the controller is idle. A `req_valid` seen while the controller is busy is ignored and changes no array contents.
- R3: A write stores `{checksum, data}` in the target chip. The checksum sits in bits `[ROW_W+7:ROW_W]` and is the sum of the data bytes modulo 256.
- R4: A write makes exactly four accesses, in this order: read the target chip, read the parity chip, write the target chip, write the parity chip. The new parity data equals old parity XOR old data XOR new data.
- R5: A read whose stored checksum matches its data makes one access and returns the data with `rsp_fixed`=0 and `rsp_fail`=0.
- R6: On a checksum mismatch, the controller reads the same row from every other data chip and then from the parity chip, in ascending index order and with no writes. It XORs their data fields. If the result matches the stored checksum, it returns the result with `rsp_fixed`=1. Such a read makes `N_DATA`+1 accesses in total.
- R7: If the rebuilt word also fails the checksum, the response has `rsp_fail`=1, `rsp_fixed`=0 and `rsp_rdata`=0.
- R8: `req_addr[DW-1:0]` selects the data chip and the upper bits select the row. The parity chip is addressed as `mem_chip`=`N_DATA`.
- R9: Every request yields exactly one single-cycle `rsp_valid` pulse. A write's response has data 0 and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | RW+DW | {row, data chip} |
| req_wdata | input | ROW_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | ROW_W | Read data (0 for writes and failures) |
| rsp_fixed | output | 1 | Data was rebuilt from parity |
| rsp_fail | output | 1 | Rebuild failed, data not valid |
| mem_en | output | 1 | Array access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_chip | output | CW | Chip index, `N_DATA` = parity chip |
| mem_row | output | RW | Row index |
| mem_wdata | output | ROW_W+8 | {checksum, data} to write |
| mem_rdata | input | ROW_W+8 | {checksum, data} read, valid the cycle after a read access |

## Verification
The in-RTL properties watch the array port on every cycle. They check that no access happens while a request could be accepted, that each data write directly follows the parity read and directly precedes the parity write, that rebuild traffic never writes, that a clean read answers right after its single target read, and that failures carry no data and responses never repeat. The bench scenarios are the only way to show the stored checksum and parity values, the access counts of each operation type, the data rebuilt after injected bit flips in the first, middle and last data chips, the uncorrectable case with two flipped chips in one row, and that a request offered mid-operation leaves memory untouched.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int SUM_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_DATA,
        S_RD_CHECK,
        S_RB_ISSUE,
        S_RB_ACC,
        S_RB_CHECK,
        S_WR_RD_DATA,
        S_WR_RD_PAR,
        S_WR_WR_DATA,
        S_WR_WR_PAR
    } rg_state_e;

endpackage

// File: rtl/rg_csum.sv
module rg_csum #(
    parameter int ROW_W = 32,
    localparam int NB = ROW_W / 8
) (
    input  logic [ROW_W-1:0]        data,
    output logic [rg_pkg::SUM_W-1:0] sum
);
    always_comb begin
        logic [rg_pkg::SUM_W-1:0] run;
        run = '0;
        for (int i = 0; i < NB; i++) begin
            run = run + data[8*i +: 8];
        end
        sum = run;
    end
endmodule

// File: rtl/rg_parity_acc.sv
module rg_parity_acc #(
    parameter int ROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ROW_W-1:0] din,
    output logic [ROW_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc ^ din;
        end
    end

    // R6: a rebuild always starts from an empty accumulator
    p_clr_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/rg_chip_walk.sv
module rg_chip_walk #(
    parameter int N_DATA = 4,
    localparam int CW = $clog2(N_DATA + 1)
) (
    input  logic [CW-1:0] tgt,
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] first,
    output logic [CW-1:0] next
);
    logic [CW-1:0] step1;
    logic [CW-1:0] step2;

    always_comb begin
        step1 = cur + CW'(1);
        step2 = cur + CW'(2);
        first = (tgt == '0) ? CW'(1) : '0;
        next  = (step1 == tgt) ? step2 : step1;
    end
endmodule

// File: rtl/rowguard_ctrl.sv
module rowguard_ctrl #(
    parameter int N_DATA = 4,
    parameter int ROW_W  = 32,
    parameter int ROWS   = 16,
    localparam int DW = (N_DATA > 1) ? $clog2(N_DATA) : 1,
    localparam int CW = $clog2(N_DATA + 1),
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int AW = RW + DW,
    localparam int MW = ROW_W + rg_pkg::SUM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [ROW_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [ROW_W-1:0] rsp_rdata,
    output logic             rsp_fixed,
    output logic             rsp_fail,
    output logic             mem_en,
    output logic             mem_we,
    output logic [CW-1:0]    mem_chip,
    output logic [RW-1:0]    mem_row,
    output logic [MW-1:0]    mem_wdata,
    input  logic [MW-1:0]    mem_rdata
);
    import rg_pkg::*;

    localparam logic [CW-1:0] PAR_IDX = CW'(N_DATA);

    rg_state_e state_q, state_d;

    logic              op_wr_q;
    logic [CW-1:0]     tgt_chip_q;
    logic [RW-1:0]     tgt_row_q;
    logic [ROW_W-1:0]  wdata_q;
    logic [ROW_W-1:0]  old_data_q;
    logic [ROW_W-1:0]  par_new_q;
    logic [SUM_W-1:0]  stored_sum_q;
    logic [CW-1:0]     walk_q;

    logic [ROW_W-1:0]  rd_data;
    logic [SUM_W-1:0]  rd_sum_field;
    logic [SUM_W-1:0]  rd_sum_calc;
    logic [SUM_W-1:0]  acc_sum_calc;
    logic [SUM_W-1:0]  wr_sum_calc;
    logic [SUM_W-1:0]  par_sum_calc;
    logic [ROW_W-1:0]  rebuilt;
    logic [CW-1:0]     walk_first;
    logic [CW-1:0]     walk_next;
    logic              acc_clr;
    logic              acc_en;
    logic              rd_clean;
    logic              rb_clean;

    assign rd_data      = mem_rdata[ROW_W-1:0];
    assign rd_sum_field = mem_rdata[MW-1:ROW_W];
    assign rd_clean     = (rd_sum_calc == rd_sum_field);
    assign rb_clean     = (acc_sum_calc == stored_sum_q);

    rg_csum #(.ROW_W(ROW_W)) u_sum_rd  (.data(rd_data),   .sum(rd_sum_calc));
    rg_csum #(.ROW_W(ROW_W)) u_sum_acc (.data(rebuilt),   .sum(acc_sum_calc));
    rg_csum #(.ROW_W(ROW_W)) u_sum_wr  (.data(wdata_q),   .sum(wr_sum_calc));
    rg_csum #(.ROW_W(ROW_W)) u_sum_par (.data(par_new_q), .sum(par_sum_calc));

    rg_parity_acc #(.ROW_W(ROW_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .din   (rd_data),
        .acc   (rebuilt)
    );

    rg_chip_walk #(.N_DATA(N_DATA)) u_walk (
        .tgt   (tgt_chip_q),
        .cur   (walk_q),
        .first (walk_first),
        .next  (walk_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (req_valid) state_d = req_write ? S_WR_RD_DATA : S_RD_DATA;
            S_RD_DATA:    state_d = S_RD_CHECK;
            S_RD_CHECK:   state_d = rd_clean ? S_IDLE : S_RB_ISSUE;
            S_RB_ISSUE:   state_d = S_RB_ACC;
            S_RB_ACC:     state_d = (walk_q == PAR_IDX) ? S_RB_CHECK : S_RB_ISSUE;
            S_RB_CHECK:   state_d = S_IDLE;
            S_WR_RD_DATA: state_d = S_WR_RD_PAR;
            S_WR_RD_PAR:  state_d = S_WR_WR_DATA;
            S_WR_WR_DATA: state_d = S_WR_WR_PAR;
            S_WR_WR_PAR:  state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // Operation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q      <= 1'b0;
            tgt_chip_q   <= '0;
            tgt_row_q    <= '0;
            wdata_q      <= '0;
            old_data_q   <= '0;
            par_new_q    <= '0;
            stored_sum_q <= '0;
            walk_q       <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        op_wr_q    <= req_write;
                        tgt_chip_q <= CW'(req_addr[DW-1:0]);
                        tgt_row_q  <= req_addr[AW-1:DW];
                        wdata_q    <= req_wdata;
                    end
                end
                S_RD_CHECK: begin
                    stored_sum_q <= rd_sum_field;
                    walk_q       <= walk_first;
                end
                S_RB_ACC:     walk_q     <= walk_next;
                S_WR_RD_PAR:  old_data_q <= rd_data;
                S_WR_WR_DATA: par_new_q  <= rd_data ^ old_data_q ^ wdata_q;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        rsp_fixed = 1'b0;
        rsp_fail  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_chip  = tgt_chip_q;
        mem_row   = tgt_row_q;
        mem_wdata = '0;
        acc_clr   = 1'b0;
        acc_en    = 1'b0;
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_RD_DATA: mem_en = 1'b1;
            S_RD_CHECK: begin
                acc_clr = 1'b1;
                if (rd_clean) begin
                    rsp_valid = 1'b1;
                    rsp_rdata = rd_data;
                end
            end
            S_RB_ISSUE: begin
                mem_en   = 1'b1;
                mem_chip = walk_q;
            end
            S_RB_ACC: acc_en = 1'b1;
            S_RB_CHECK: begin
                rsp_valid = 1'b1;
                if (rb_clean) begin
                    rsp_rdata = rebuilt;
                    rsp_fixed = 1'b1;
                end else begin
                    rsp_fail  = 1'b1;
                end
            end
            S_WR_RD_DATA: mem_en = 1'b1;
            S_WR_RD_PAR: begin
                mem_en   = 1'b1;
                mem_chip = PAR_IDX;
            end
            S_WR_WR_DATA: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {wr_sum_calc, wdata_q};
            end
            S_WR_WR_PAR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_chip  = PAR_IDX;
                mem_wdata = {par_sum_calc, par_new_q};
                rsp_valid = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: no array traffic while a new request could be taken
    p_busy_blocks_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    // R9: responses are single-cycle pulses
    p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: parity write directly follows the data write
    p_par_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_chip == PAR_IDX)
        |-> $past(mem_en && mem_we && mem_chip != PAR_IDX));

    // R4: data write directly follows the parity read
    p_data_after_par_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_chip != PAR_IDX)
        |-> $past(mem_en && !mem_we && mem_chip == PAR_IDX));

    // R5: a clean read answers right after its single target read
    p_clean_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !op_wr_q && !rsp_fixed && !rsp_fail)
        |-> $past(mem_en && !mem_we && mem_chip == tgt_chip_q));

    // R6: rebuild traffic never writes
    p_rebuild_reads_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !op_wr_q && mem_chip != tgt_chip_q) |-> !mem_we);

    // R7: failed rebuild carries no data
    p_fail_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> (rsp_rdata == '0 && !rsp_fixed));
endmodule

// File: tb/tb_rowguard_ctrl.sv
`timescale 1ns/1ps
module tb_rowguard_ctrl;
    localparam int N_DATA = 4;
    localparam int ROW_W  = 32;
    localparam int ROWS   = 16;
    localparam int DW = 2;
    localparam int CW = 3;
    localparam int RW = 4;
    localparam int AW = RW + DW;
    localparam int MW = ROW_W + 8;

    logic             clk;
    logic             rst_n;
    logic             req_valid;
    logic             req_ready;
    logic             req_write;
    logic [AW-1:0]    req_addr;
    logic [ROW_W-1:0] req_wdata;
    logic             rsp_valid;
    logic [ROW_W-1:0] rsp_rdata;
    logic             rsp_fixed;
    logic             rsp_fail;
    logic             mem_en;
    logic             mem_we;
    logic [CW-1:0]    mem_chip;
    logic [RW-1:0]    mem_row;
    logic [MW-1:0]    mem_wdata;
    logic [MW-1:0]    mem_rdata;

    rowguard_ctrl #(.N_DATA(N_DATA), .ROW_W(ROW_W), .ROWS(ROWS)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_fixed(rsp_fixed), .rsp_fail(rsp_fail),
        .mem_en(mem_en), .mem_we(mem_we), .mem_chip(mem_chip),
        .mem_row(mem_row), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Chip models plus fault injection
    logic [MW-1:0]    marr [0:N_DATA][0:ROWS-1];
    logic             inj_en;
    int               inj_chip;
    int               inj_row;
    logic [ROW_W-1:0] inj_mask;
    int               acc_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c <= N_DATA; c++)
                for (int r = 0; r < ROWS; r++) marr[c][r] <= '0;
            mem_rdata <= '0;
            acc_cnt   <= 0;
        end else begin
            if (inj_en)
                marr[inj_chip][inj_row] <= marr[inj_chip][inj_row] ^ {8'h00, inj_mask};
            if (mem_en) begin
                acc_cnt <= acc_cnt + 1;
                if (mem_we) marr[mem_chip][mem_row] <= mem_wdata;
                else        mem_rdata <= marr[mem_chip][mem_row];
            end
        end
    end

    int n_chk;
    int n_fail;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] tb_sum(input logic [ROW_W-1:0] d);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < ROW_W / 8; i++) s = s + d[8*i +: 8];
        return s;
    endfunction

    // Scoreboard
    typedef struct {
        logic [ROW_W-1:0] d;
        logic             fx;
        logic             fl;
        int               acc;
        string            req;
    } exp_t;

    exp_t q[$];
    logic [ROW_W-1:0] sh [0:N_DATA-1][0:ROWS-1];
    int base;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            int got;
            got  = acc_cnt + (mem_en ? 1 : 0) - base;
            base = acc_cnt + (mem_en ? 1 : 0);
            if (q.size() == 0) begin
                chk(1'b0, "R9 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_rdata == e.d,  {e.req, " data"},  rsp_rdata, e.d);
                chk(rsp_fixed == e.fx, {e.req, " fixed"}, rsp_fixed, e.fx);
                chk(rsp_fail == e.fl,  {e.req, " fail"},  rsp_fail,  e.fl);
                chk(got == e.acc,      {e.req, " accesses"}, got, e.acc);
            end
        end
    end

    task automatic op(input logic wr, input int row, input int chip,
                      input logic [ROW_W-1:0] wd, input logic [ROW_W-1:0] ed,
                      input logic efx, input logic efl, input int eacc,
                      input string req, input bit junk);
        exp_t e;
        e.d = ed; e.fx = efx; e.fl = efl; e.acc = eacc; e.req = req;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {RW'(row), DW'(chip)};
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        if (junk) begin
            req_write = 1'b1;
            req_addr  = {RW'(5), DW'(0)};
            req_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
        end
        req_valid = 1'b0;
        do @(posedge clk); while (q.size() != 0);
        @(negedge clk);
        if (wr) sh[chip][row] = wd;
    endtask

    task automatic wr_op(input int row, input int chip, input logic [ROW_W-1:0] wd);
        op(1'b1, row, chip, wd, '0, 1'b0, 1'b0, 4, "R4 R9 write", 1'b0);
    endtask

    task automatic chk_store(input int row, input int chip);
        logic [ROW_W-1:0] p;
        p = '0;
        for (int c = 0; c < N_DATA; c++) p = p ^ sh[c][row];
        chk(marr[chip][row] == {tb_sum(sh[chip][row]), sh[chip][row]},
            "R3 R8 stored word", marr[chip][row], {tb_sum(sh[chip][row]), sh[chip][row]});
        chk(marr[N_DATA][row][ROW_W-1:0] == p, "R4 parity word",
            marr[N_DATA][row][ROW_W-1:0], p);
    endtask

    task automatic inject(input int chip, input int row, input logic [ROW_W-1:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_chip = chip; inj_row = row; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        n_chk = 0; n_fail = 0; base = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        inj_en = 1'b0; inj_chip = 0; inj_row = 0; inj_mask = '0;
        for (int c = 0; c < N_DATA; c++)
            for (int r = 0; r < ROWS; r++) sh[c][r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
        chk(mem_en == 1'b0, "R1 no access after reset", mem_en, 0);

        for (int r = 1; r <= 3; r++) begin
            for (int c = 0; c < N_DATA; c++) begin
                wr_op(r, c, 32'hA5C3_0F00 ^ (r * 32'h0011_0100) ^ (c * 32'h0101_0107));
                chk_store(r, c);
            end
        end
        wr_op(1, 2, 32'hFFFF_FF01);
        chk_store(1, 2);
        wr_op(2, 3, 32'h0000_0000);
        chk_store(2, 3);

        for (int c = 0; c < N_DATA; c++)
            op(1'b0, 1, c, '0, sh[c][1], 1'b0, 1'b0, 1, "R5 clean read", 1'b0);
        op(1'b0, 9, 3, '0, '0, 1'b0, 1'b0, 1, "R5 unwritten row", 1'b0);

        inject(2, 2, 32'h0000_0020);
        op(1'b0, 2, 2, '0, sh[2][2], 1'b1, 1'b0, N_DATA + 1, "R6 rebuild middle chip", 1'b0);
        inject(0, 1, 32'h8000_0000);
        op(1'b0, 1, 0, '0, sh[0][1], 1'b1, 1'b0, N_DATA + 1, "R6 rebuild first chip", 1'b0);
        inject(3, 3, 32'h0001_0000);
        op(1'b0, 3, 3, '0, sh[3][3], 1'b1, 1'b0, N_DATA + 1, "R6 R8 rebuild last chip", 1'b0);
        chk(marr[2][2][ROW_W-1:0] == (sh[2][2] ^ 32'h20), "R6 rebuild leaves arrays",
            marr[2][2][ROW_W-1:0], sh[2][2] ^ 32'h20);

        inject(1, 2, 32'h0000_0400);
        op(1'b0, 2, 1, '0, '0, 1'b0, 1'b1, N_DATA + 1, "R7 two chips bad", 1'b0);
        op(1'b0, 2, 2, '0, '0, 1'b0, 1'b1, N_DATA + 1, "R7 two chips bad again", 1'b0);

        op(1'b0, 3, 0, '0, sh[0][3], 1'b0, 1'b0, 1, "R2 read with request offered while busy", 1'b1);
        chk(marr[0][5] == '0, "R2 busy request ignored", marr[0][5], 0);
        op(1'b0, 5, 0, '0, '0, 1'b0, 1'b0, 1, "R2 R5 untouched row", 1'b0);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R9 all responses seen", q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule